// File: doc/BRIEF.md
# Multi-Queue Almost-Full Flag Bus

This block tracks the fill level of four local queues and reports, for each one, whether it has reached its own programmable almost-full level. The queue memories themselves are outside the block and appear here only as occupancy counters, raised by accepted writes and lowered by accepted reads. The queue chosen by the most recent write to this device also drives two discrete flags, full and almost-full. All flags are active-low.

Up to eight identical devices can tie their 4-bit almost-full buses together. Each device has a static 3-bit chip ID. The upper bits of the 5-bit write address select a device, and the lower two bits select a queue inside it. Only one device may drive the shared bus at a time, and every other device holds its bus pins at high impedance.

Which device drives the bus is set by one of two ownership modes, latched while reset is held. In addressed mode, a strobe picks the device whose ID equals the upper write-address bits. In rotating mode, a counter in each device, started together by the common reset, passes ownership from ID to ID.

Top module: `qflag_bus`

## Requirements
- R1: While `rst` is high, every queue occupancy clears to 0 and every threshold loads DEPTH-AF_GAP. The outputs are then `full_n_o`=1, `afull_n_o`=1 and `paf_oe_o`=0, and the rotation counter is 0.
- R2: A write is accepted only when `wr_en_i` is high and `wr_addr_i[4:2]` equals `chip_id_i`. It targets the queue numbered `wr_addr_i[1:0]`. Writes that name another ID leave every local queue unchanged.
- R3: A queue counts as full at DEPTH entries. A write to a full queue is ignored, and so is a read (`rd_en_i`, queue `rd_q_i`) from an empty queue. A read and a write in the same cycle are each judged on the occupancy before the clock edge. `full_n_o` is 0 exactly when the active queue holds DEPTH entries.
- R4: Bus bit i (bit 0 = queue 0 … bit 3 = queue 3) is 0 when queue i's occupancy is at or above its threshold. Bits for queue indices at or above NUM_Q always read 1.
- R5: `cfg_we_i` loads `cfg_thr_i` as the threshold of queue `cfg_q_i`. A value above DEPTH is stored as DEPTH.
- R6: Every accepted-address write (R2, even when it is ignored for fullness) makes `wr_addr_i[1:0]` the active queue. `full_n_o` and `afull_n_o` show that queue's state from the clock edge that performs the write.
- R7: `mode_sel_i` is sampled only while `rst` is high (0 = addressed, 1 = rotating). Changes to it outside reset have no effect.
- R8: In addressed mode, `fstr_i` with `wr_addr_i[4:2]` equal to `chip_id_i` sets `paf_oe_o` at the next edge. `fstr_i` with any other ID clears it. Without a strobe, `paf_oe_o` holds.
- R9: In rotating mode, the rotation counter steps by one each cycle after reset and wraps at 2^IDW. `paf_oe_o` is 1 exactly in the cycles where the counter equals `chip_id_i`. The strobe is ignored in this mode.
- R10: `paf_io` carries the almost-full bits when `paf_oe_o` is 1 and is high impedance otherwise. Devices with distinct IDs sharing one reset never drive it together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| mode_sel_i | input | 1 | Bus ownership mode, sampled during reset (0 addressed, 1 rotating) |
| chip_id_i | input | IDW | Static device ID |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | IDW+2 | Write address: device ID on top, queue index in bits [1:0] |
| rd_en_i | input | 1 | Read request |
| rd_q_i | input | 2 | Queue being read |
| cfg_we_i | input | 1 | Threshold load |
| cfg_q_i | input | 2 | Queue whose threshold is loaded |
| cfg_thr_i | input | CW | New threshold value |
| fstr_i | input | 1 | Flag-bus ownership strobe (addressed mode) |
| full_n_o | output | 1 | Active queue full, active-low |
| afull_n_o | output | 1 | Active queue almost full, active-low |
| paf_oe_o | output | 1 | This device is driving the shared bus |
| paf_io | inout | 4 | Shared per-queue almost-full bus, active-low, tri-stated |

## Verification
A wrong occupancy counter does not show up right away. It appears at the ports later, when that queue's bus bit or discrete flag crosses its threshold or the full level at a different write count than the reference model predicts, so the bench compares every flag on every clock and fills queues all the way to both levels. A wrong active-queue register shows up on the first edge after a write, as discrete flags that belong to the wrong queue. A wrong ownership register shows up in the same cycle: a second bus driver, a silent bus, or a rotation slot that falls on the wrong cycle.

// File: rtl/qfb_pkg.sv
package qfb_pkg;
  localparam int QFB_BUS_W = 4;
  localparam int QFB_QAW   = 2;

  typedef enum logic {
    FM_ADDRESSED = 1'b0,
    FM_ROTATING  = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/qfb_queue_stat.sv
module qfb_queue_stat #(
  parameter int DEPTH   = 16,
  parameter int CW      = 5,
  parameter int THR_RST = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_thr,
  output logic [CW-1:0] occ_o,
  output logic          full_nx_o,
  output logic          af_nx_o
);
  localparam logic [CW-1:0] LIM = CW'(DEPTH);

  logic [CW-1:0] occ_q, occ_nx;
  logic [CW-1:0] thr_q, thr_nx;
  logic          wr_ok, rd_ok;

  always_comb begin
    wr_ok = wr_req && (occ_q != LIM);
    rd_ok = rd_req && (occ_q != '0);
    case ({wr_ok, rd_ok})
      2'b10:   occ_nx = occ_q + 1'b1;
      2'b01:   occ_nx = occ_q - 1'b1;
      default: occ_nx = occ_q;
    endcase
    thr_nx = thr_q;
    if (cfg_we) thr_nx = (cfg_thr > LIM) ? LIM : cfg_thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      thr_q <= CW'(THR_RST);
    end else begin
      occ_q <= occ_nx;
      thr_q <= thr_nx;
    end
  end

  assign occ_o     = occ_q;
  assign full_nx_o = (occ_nx == LIM);
  assign af_nx_o   = (occ_nx >= thr_nx);
endmodule

// File: rtl/qfb_active_sel.sv
module qfb_active_sel #(
  parameter int NQ  = 4,
  parameter int QAW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_we,
  input  logic [QAW-1:0] sel_q,
  input  logic [NQ-1:0]  full_nx,
  input  logic [NQ-1:0]  af_nx,
  output logic           full_n_o,
  output logic           afull_n_o
);
  logic [QAW-1:0] act_q, act_nx;

  assign act_nx = sel_we ? sel_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      full_n_o  <= 1'b1;
      afull_n_o <= 1'b1;
    end else begin
      act_q     <= act_nx;
      full_n_o  <= ~full_nx[act_nx];
      afull_n_o <= ~af_nx[act_nx];
    end
  end
endmodule

// File: rtl/qfb_bus_owner.sv
module qfb_bus_owner
  import qfb_pkg::*;
#(
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_sel_i,
  input  logic [IDW-1:0] chip_id_i,
  input  logic           fstr_i,
  input  logic [IDW-1:0] addr_id_i,
  output logic           mode_o,
  output logic [IDW-1:0] poll_o,
  output logic           oe_o
);
  flag_mode_e     mode_q;
  logic [IDW-1:0] poll_q, poll_nx;

  assign poll_nx = poll_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= flag_mode_e'(mode_sel_i);
      poll_q <= '0;
      oe_o   <= 1'b0;
    end else begin
      poll_q <= poll_nx;
      if (mode_q == FM_ROTATING) oe_o <= (poll_nx == chip_id_i);
      else if (fstr_i)           oe_o <= (addr_id_i == chip_id_i);
    end
  end

  assign mode_o = mode_q;
  assign poll_o = poll_q;
endmodule

// File: rtl/qflag_bus.sv
module qflag_bus
  import qfb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AF_GAP = 2,
  parameter int NUM_Q  = 4,
  parameter int IDW    = 3,
  localparam int QAW    = QFB_QAW,
  localparam int NQ     = QFB_BUS_W,
  localparam int ADDR_W = IDW + QAW,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel_i,
  input  logic [IDW-1:0]    chip_id_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_en_i,
  input  logic [QAW-1:0]    rd_q_i,
  input  logic              cfg_we_i,
  input  logic [QAW-1:0]    cfg_q_i,
  input  logic [CW-1:0]     cfg_thr_i,
  input  logic              fstr_i,
  output logic              full_n_o,
  output logic              afull_n_o,
  output logic              paf_oe_o,
  inout  wire  [NQ-1:0]     paf_io
);
  localparam int THR_RST = DEPTH - AF_GAP;

  logic                    wr_hit;
  logic [NQ-1:0]           full_nx, af_nx;
  logic [NQ-1:0][CW-1:0]   occ_v;
  logic [NQ-1:0]           paf_q;
  logic                    mode_q;
  logic [IDW-1:0]          poll_q;

  assign wr_hit = wr_en_i && (wr_addr_i[ADDR_W-1:QAW] == chip_id_i);

  for (genvar gq = 0; gq < NQ; gq++) begin : g_q
    if (gq < NUM_Q) begin : g_live
      qfb_queue_stat #(
        .DEPTH(DEPTH), .CW(CW), .THR_RST(THR_RST)
      ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_hit && (wr_addr_i[QAW-1:0] == QAW'(gq))),
        .rd_req   (rd_en_i && (rd_q_i == QAW'(gq))),
        .cfg_we   (cfg_we_i && (cfg_q_i == QAW'(gq))),
        .cfg_thr  (cfg_thr_i),
        .occ_o    (occ_v[gq]),
        .full_nx_o(full_nx[gq]),
        .af_nx_o  (af_nx[gq])
      );
    end else begin : g_idle
      assign occ_v[gq]   = '0;
      assign full_nx[gq] = 1'b0;
      assign af_nx[gq]   = 1'b0;
    end
  end

  qfb_active_sel #(.NQ(NQ), .QAW(QAW)) u_act (
    .clk      (clk),
    .rst      (rst),
    .sel_we   (wr_hit),
    .sel_q    (wr_addr_i[QAW-1:0]),
    .full_nx  (full_nx),
    .af_nx    (af_nx),
    .full_n_o (full_n_o),
    .afull_n_o(afull_n_o)
  );

  qfb_bus_owner #(.IDW(IDW)) u_own (
    .clk       (clk),
    .rst       (rst),
    .mode_sel_i(mode_sel_i),
    .chip_id_i (chip_id_i),
    .fstr_i    (fstr_i),
    .addr_id_i (wr_addr_i[ADDR_W-1:QAW]),
    .mode_o    (mode_q),
    .poll_o    (poll_q),
    .oe_o      (paf_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) paf_q <= '1;
    else     paf_q <= ~af_nx;
  end

  assign paf_io = paf_oe_o ? paf_q : {NQ{1'bz}};
endmodule

// File: rtl/qfb_chk.sv
module qfb_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int NQ    = 4,
  parameter int IDW   = 3,
  parameter int QAW   = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [IDW+QAW-1:0]    wr_addr_i,
  input logic [IDW-1:0]        chip_id_i,
  input logic                  fstr_i,
  input logic                  full_n_o,
  input logic                  afull_n_o,
  input logic                  paf_oe_o,
  input logic                  mode_q,
  input logic [IDW-1:0]        poll_q,
  input logic [NQ-1:0][CW-1:0] occ_v
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (full_n_o && afull_n_o && !paf_oe_o && poll_q == '0));

  a_r3_full_implies_af: assert property (@(posedge clk) disable iff (rst)
    !full_n_o |-> !afull_n_o);

  always_comb begin
    if (!rst) begin
      for (int i = 0; i < NQ; i++) begin
        a_r3_occ_bound: assert (occ_v[i] <= CW'(DEPTH));
      end
    end
  end

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));

  a_r8_take: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && fstr_i && wr_addr_i[IDW+QAW-1:QAW] == chip_id_i) |=> paf_oe_o);

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && fstr_i && wr_addr_i[IDW+QAW-1:QAW] != chip_id_i) |=> !paf_oe_o);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !fstr_i) |=> $stable(paf_oe_o));

  a_r9_poll_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (poll_q == IDW'($past(poll_q) + 1'b1)));

  a_r9_oe_slot: assert property (@(posedge clk) disable iff (rst)
    (mode_q && paf_oe_o) |-> (poll_q == chip_id_i));
endmodule

bind qflag_bus qfb_chk #(
  .DEPTH(DEPTH), .CW(CW), .NQ(NQ), .IDW(IDW), .QAW(QAW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_addr_i(wr_addr_i),
  .chip_id_i(chip_id_i),
  .fstr_i   (fstr_i),
  .full_n_o (full_n_o),
  .afull_n_o(afull_n_o),
  .paf_oe_o (paf_oe_o),
  .mode_q   (mode_q),
  .poll_q   (poll_q),
  .occ_v    (occ_v)
);

// File: tb/sim_qflag_bus.sv
module sim_qflag_bus;
  localparam int DEPTH = 16;
  localparam int GAP   = 2;
  localparam int CW    = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, mode_sel = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0, fstr = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [1:0] rd_q = '0, cfg_q = '0;
  logic [CW-1:0] cfg_thr = '0;
  logic [1:0] fn, afn, oe;
  tri   [3:0] shared_bus;

  qflag_bus #(.DEPTH(DEPTH), .AF_GAP(GAP), .NUM_Q(4)) u0 (
    .clk(clk), .rst(rst), .mode_sel_i(mode_sel), .chip_id_i(3'd3),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .rd_en_i(rd_en), .rd_q_i(rd_q),
    .cfg_we_i(cfg_we), .cfg_q_i(cfg_q), .cfg_thr_i(cfg_thr), .fstr_i(fstr),
    .full_n_o(fn[0]), .afull_n_o(afn[0]), .paf_oe_o(oe[0]), .paf_io(shared_bus));

  qflag_bus #(.DEPTH(DEPTH), .AF_GAP(GAP), .NUM_Q(3)) u1 (
    .clk(clk), .rst(rst), .mode_sel_i(mode_sel), .chip_id_i(3'd5),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .rd_en_i(rd_en), .rd_q_i(rd_q),
    .cfg_we_i(cfg_we), .cfg_q_i(cfg_q), .cfg_thr_i(cfg_thr), .fstr_i(fstr),
    .full_n_o(fn[1]), .afull_n_o(afn[1]), .paf_oe_o(oe[1]), .paf_io(shared_bus));

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_occ[2][4];
  int m_thr[2][4];
  int m_act[2];
  int m_poll[2];
  bit m_oe[2];
  bit m_mode[2];
  int m_nq[2] = '{4, 3};
  int m_id[2] = '{3, 5};

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        for (int q = 0; q < 4; q++) begin
          m_occ[d][q] = 0;
          m_thr[d][q] = DEPTH - GAP;
        end
        m_act[d] = 0; m_poll[d] = 0; m_oe[d] = 0; m_mode[d] = mode_sel;
      end else begin
        bit hit;
        hit = wr_en && (int'(wr_addr[4:2]) == m_id[d]);
        for (int q = 0; q < 4; q++) begin
          bit w, r;
          w = hit && int'(wr_addr[1:0]) == q && q < m_nq[d] && m_occ[d][q] < DEPTH;
          r = rd_en && int'(rd_q) == q && q < m_nq[d] && m_occ[d][q] > 0;
          m_occ[d][q] = m_occ[d][q] + int'(w) - int'(r);
          if (cfg_we && int'(cfg_q) == q && q < m_nq[d])
            m_thr[d][q] = (int'(cfg_thr) > DEPTH) ? DEPTH : int'(cfg_thr);
        end
        if (hit) m_act[d] = int'(wr_addr[1:0]);
        m_poll[d] = (m_poll[d] + 1) % 8;
        if (m_mode[d]) m_oe[d] = (m_poll[d] == m_id[d]);
        else if (fstr) m_oe[d] = (int'(wr_addr[4:2]) == m_id[d]);
      end
    end
  end

  function automatic bit exp_full_n(int d);
    int a = m_act[d];
    return !(a < m_nq[d] && m_occ[d][a] == DEPTH);
  endfunction

  function automatic bit exp_af_n(int d);
    int a = m_act[d];
    return !(a < m_nq[d] && m_occ[d][a] >= m_thr[d][a]);
  endfunction

  function automatic logic [3:0] exp_paf(int d);
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = (i < m_nq[d]) ? !(m_occ[d][i] >= m_thr[d][i]) : 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int d = 0; d < 2; d++) begin
        chk(fn[d] == exp_full_n(d), $sformatf("R3 full_n dev%0d", d), fn[d], exp_full_n(d));
        chk(afn[d] == exp_af_n(d), $sformatf("R6 afull_n dev%0d", d), afn[d], exp_af_n(d));
        chk(oe[d] == m_oe[d], m_mode[d] ? "R9 rotate oe" : "R8 addressed oe", oe[d], m_oe[d]);
      end
      chk($countones(oe) <= 1, "R10 single driver", $countones(oe), 1);
      if (oe == 2'b01) chk(shared_bus === exp_paf(0), "R4 bus dev0", shared_bus, exp_paf(0));
      if (oe == 2'b10) chk(shared_bus === exp_paf(1), "R4 bus dev1", shared_bus, exp_paf(1));
    end
  end

  task automatic drive(input bit we, input logic [4:0] a, input bit re, input logic [1:0] rq,
                       input bit fs, input bit cw, input logic [1:0] cq, input logic [CW-1:0] ct);
    wr_en = we; wr_addr = a; rd_en = re; rd_q = rq; fstr = fs;
    cfg_we = cw; cfg_q = cq; cfg_thr = ct;
    @(negedge clk);
  endtask

  task automatic idle();             drive(0, '0, 0, '0, 0, 0, '0, '0); endtask
  task automatic wr(input logic [2:0] id, input logic [1:0] q); drive(1, {id, q}, 0, '0, 0, 0, '0, '0); endtask
  task automatic rd(input logic [1:0] q); drive(0, '0, 1, q, 0, 0, '0, '0); endtask
  task automatic strobe(input logic [2:0] id); drive(0, {id, 2'b00}, 0, '0, 1, 0, '0, '0); endtask
  task automatic cfg(input logic [1:0] q, input int v); drive(0, '0, 0, '0, 0, 1, q, CW'(v)); endtask

  task automatic random_run(input int n, inout logic [31:0] s);
    for (int i = 0; i < n; i++) begin
      logic [2:0] id;
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      id = s[6] ? 3'd3 : (s[7] ? 3'd5 : s[10:8]);
      drive(s[0] | s[1], {id, s[3:2]}, s[11] & s[12], s[14:13], s[28] & s[29],
            s[20:17] == 4'd0, s[22:21], s[27:23]);
    end
  endtask

  initial begin
    logic [31:0] seed = 32'h1ACE_B00C;
    int c0, c1;
    @(negedge clk);
    cmp_on = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(fn == 2'b11, "R1 full_n after reset", fn, 3);
    chk(afn == 2'b11, "R1 afull_n after reset", afn, 3);
    chk(oe == 2'b00, "R1 oe after reset", oe, 0);

    strobe(3);
    chk(oe == 2'b01, "R8 strobe selects dev id 3", oe, 1);

    repeat (13) wr(3, 1);
    chk(afn[0] == 1, "R4 below threshold", afn[0], 1);
    chk(shared_bus[1] === 1'b1, "R4 bus bit1 below threshold", shared_bus[1], 1);
    wr(3, 1);
    chk(afn[0] == 0, "R4 at threshold", afn[0], 0);
    chk(shared_bus[1] === 1'b0, "R4 bus bit1 at threshold", shared_bus[1], 0);
    chk(fn[0] == 1, "R3 not full at 14", fn[0], 1);
    repeat (2) wr(3, 1);
    chk(fn[0] == 0, "R3 full at DEPTH", fn[0], 0);
    wr(3, 1);
    rd(1);
    chk(fn[0] == 1, "R3 write to full ignored", fn[0], 1);

    // R2 foreign writes
    repeat (3) wr(5, 1);
    wr(7, 1);
    chk(afn[0] == 0, "R2 foreign writes keep active flag", afn[0], 0);
    rd(1); rd(1);
    chk(afn[0] == 1, "R2 foreign writes not counted", afn[0], 1);

    // R5 / R6
    cfg(0, 1);
    chk(shared_bus[0] === 1'b1, "R5 empty queue under threshold 1", shared_bus[0], 1);
    wr(3, 0);
    chk(afn[0] == 0, "R6 active switched to queue 0", afn[0], 0);
    chk(shared_bus[0] === 1'b0, "R5 threshold 1 reached", shared_bus[0], 0);
    cfg(2, 20);
    repeat (15) wr(3, 2);
    chk(afn[0] == 1, "R5 threshold clamped to DEPTH", afn[0], 1);
    wr(3, 2);
    chk(afn[0] == 0 && fn[0] == 0, "R5 clamped threshold hit at full", {fn[0], afn[0]}, 0);
    wr(3, 1);
    chk(fn[0] == 1, "R6 flags follow new active queue", fn[0], 1);

    // R8 ownership hand-over
    strobe(5);
    chk(oe == 2'b10, "R8 strobe moves bus to id 5", oe, 2);
    chk(shared_bus[3] === 1'b1, "R4 unused bit reads 1", shared_bus[3], 1);
    strobe(7);
    chk(oe == 2'b00, "R8 strobe to absent id releases", oe, 0);
    idle(); idle();
    chk(oe == 2'b00, "R8 no strobe holds", oe, 0);

    // R7 mode ignored outside reset
    mode_sel = 1;
    repeat (3) idle();
    strobe(3);
    chk(oe == 2'b01, "R7 mode still addressed", oe, 1);
    mode_sel = 0;

    // R9 rotating mode
    mode_sel = 1; rst = 1;
    idle(); idle();
    rst = 0; mode_sel = 0;
    chk(oe == 2'b00, "R1 oe cleared by reset", oe, 0);
    c0 = 0; c1 = 0;
    for (int i = 0; i < 8; i++) begin
      idle();
      c0 += int'(oe[0]);
      c1 += int'(oe[1]);
    end
    chk(c0 == 1, "R9 dev id 3 one slot per lap", c0, 1);
    chk(c1 == 1, "R9 dev id 5 one slot per lap", c1, 1);
    random_run(400, seed);

    // random run in addressed mode
    rst = 1; idle(); rst = 0;
    random_run(400, seed);
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule